// File: doc/BRIEF.md
# Dual-Select Static RAM with Output Disable

This block is a synthesizable model of a 1024-word by 4-bit static RAM. A 10-bit address picks one word. The bidirectional data pin is split into three signals: a data-in bus, a data-out bus and an output-enable flag. Pad logic outside the block combines them into a three-state pin.

The part is selected only when its active-low select is 0 and its active-high select is 1. A write strobe, active low, turns the data port into an input and stores the word on a clock edge; that clock stands in for the tester cycle. With the strobe high, the part selected and the output-disable input low, the block drives the addressed word.

In every other case the output enable is off and data-out rests at zero. This includes the whole time the write strobe is low, so the block never contends with a driver outside it.

Top module: `dsel_sram`

## Requirements
- R1: The array holds 2^10 = 1024 words of 4 bits each. Every address keeps its own word, independent of writes to every other address.
- R2: The part is selected only when `sel_lo_n` is 0 and `sel_hi` is 1. Only then can a write or a drive happen.
- R3: While `sel_lo_n` is 1, `doe` is 0 and no word is written, whatever `wr_n`, `din` and `addr` are.
- R4: While `sel_hi` is 0, `doe` is 0 and no word is written, whatever `wr_n`, `din` and `addr` are.
- R5: While `out_off` is 1, `doe` is 0 and `dout` is 0, even with the part selected. A selected write still takes effect while `out_off` is 1.
- R6: While `wr_n` is 0, `doe` is 0, so the port is an input.
- R7: A write stores the value of `din` sampled at the rising clock edge at which `wr_n` is 0, the part is selected and `rst_n` is 1. Changes to `din` after that edge do not alter the stored word.
- R8: With `wr_n` 1, the part selected, `out_off` 0 and `rst_n` 1, `doe` is 1 and `dout` shows the word at `addr` in the same cycle, with no clock delay. Whenever `doe` is 0, `dout` is 0.
- R9: While `rst_n` is 0, `doe` is 0 and no word is written. Reset does not clear the array: a word written before reset reads back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cycle clock; writes land on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes and drive |
| addr | input | 10 | Word address |
| din | input | 4 | Data presented to the port by the outside |
| wr_n | input | 1 | Write strobe, active low |
| sel_lo_n | input | 1 | Select, active low |
| sel_hi | input | 1 | Select, active high |
| out_off | input | 1 | Output disable, active high |
| dout | output | 4 | Word driven onto the port, zero when not driving |
| doe | output | 1 | Port drive enable |

## Verification
On every cycle, the assertions check four rules:
- The port is never driven while the strobe is low, while either select is inactive, while the output is disabled or while reset is held.
- `dout` is zero whenever `doe` is off.
- A blocked select never produces a write.
- A write followed by a read of the same address returns the word sampled at the edge.

Three behaviours are shown only by the bench's scenarios:
- every one of the 1024 addresses holds its own word;
- a refused write leaves the old word intact, and a write during output disable does land;
- the array survives a reset.

These depend on long-lived storage, which the bench reads back through the port.

// File: rtl/dsel_sram_pkg.sv
package dsel_sram_pkg;

  // Control modes the port can be in during one cycle.
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_WRITE = 2'd1,
    PORT_READ  = 2'd2
  } port_mode_e;

  // Both selects must be at their active level.
  function automatic logic both_selected(input logic lo_n, input logic hi);
    return (lo_n == 1'b0) && (hi == 1'b1);
  endfunction

  // Resolve the cycle's port mode from the control pins.
  function automatic port_mode_e resolve_mode(input logic run,
                                               input logic sel,
                                               input logic strobe_n,
                                               input logic off);
    port_mode_e m;
    m = PORT_IDLE;
    if (run && sel) begin
      if (!strobe_n)  m = PORT_WRITE;
      else if (!off)  m = PORT_READ;
    end
    return m;
  endfunction

endpackage

// File: rtl/dss_decode.sv
module dss_decode
  import dsel_sram_pkg::*;
(
  input  logic rst_n,
  input  logic wr_n,
  input  logic sel_lo_n,
  input  logic sel_hi,
  input  logic out_off,
  output logic sel,
  output logic wr_fire,
  output logic rd_fire
);

  port_mode_e mode;

  always_comb begin
    sel     = both_selected(sel_lo_n, sel_hi);
    mode    = resolve_mode(rst_n, sel, wr_n, out_off);
    wr_fire = (mode == PORT_WRITE);
    rd_fire = (mode == PORT_READ);
  end

endmodule

// File: rtl/dss_array.sv
module dss_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end

  assign rd_data = mem[addr];

endmodule

// File: rtl/dss_drive.sv
module dss_drive #(
  parameter int DATA_W = 4
) (
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] dout,
  output logic              doe
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign dout[b] = rd_fire & word[b];
  end

  assign doe = rd_fire;

endmodule

// File: rtl/dsel_sram.sv
module dsel_sram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_n,
  input  logic              sel_lo_n,
  input  logic              sel_hi,
  input  logic              out_off,
  output logic [DATA_W-1:0] dout,
  output logic              doe
);

  // Internal events, named for the checker.
  logic              sel;
  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] word;

  dss_decode u_decode (
    .rst_n    (rst_n),
    .wr_n     (wr_n),
    .sel_lo_n (sel_lo_n),
    .sel_hi   (sel_hi),
    .out_off  (out_off),
    .sel      (sel),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire)
  );

  dss_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .wr_en   (wr_fire),
    .addr    (addr),
    .wr_data (din),
    .rd_data (word)
  );

  dss_drive #(.DATA_W(DATA_W)) u_drive (
    .rd_fire (rd_fire),
    .word    (word),
    .dout    (dout),
    .doe     (doe)
  );

endmodule

// File: rtl/dsel_sram_chk.sv
module dsel_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic              wr_n,
  input logic              sel_lo_n,
  input logic              sel_hi,
  input logic              out_off,
  input logic [DATA_W-1:0] dout,
  input logic              doe,
  input logic              sel,
  input logic              wr_fire
);

  a_r6_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !doe);

  a_r3_lo_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lo_n |-> (!doe && !wr_fire));

  a_r4_hi_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hi |-> (!doe && !wr_fire));

  a_r5_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_off |-> (!doe && dout == '0));

  a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !doe |-> dout == '0);

  a_r2_drive_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> sel);

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_fire) && doe && addr == $past(addr)) |-> dout == $past(din));

  // R9: no drive while reset is held
  always_comb begin
    if (rst_n === 1'b0) a_r9_reset_quiet: assert (doe === 1'b0);
  end

endmodule

bind dsel_sram dsel_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .din      (din),
  .wr_n     (wr_n),
  .sel_lo_n (sel_lo_n),
  .sel_hi   (sel_hi),
  .out_off  (out_off),
  .dout     (dout),
  .doe      (doe),
  .sel      (sel),
  .wr_fire  (wr_fire)
);

// File: tb/test_dsel_sram.sv
module test_dsel_sram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 4;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          wr_n = 1'b1;
  logic          sel_lo_n = 1'b1;
  logic          sel_hi = 1'b0;
  logic          out_off = 1'b1;
  logic [DW-1:0] dout;
  logic          doe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsel_sram #(.ADDR_W(AW), .DATA_W(DW)) i_dsel_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .wr_n(wr_n),
    .sel_lo_n(sel_lo_n), .sel_hi(sel_hi), .out_off(out_off),
    .dout(dout), .doe(doe)
  );

  // Pattern word for an address.
  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 7) ^ (a >> 5) ^ (a >> 9));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [DW-1:0] d,
                     input logic lo_n, input logic hi, input logic off);
    @(negedge clk);
    addr = AW'(a); din = d; wr_n = 1'b0;
    sel_lo_n = lo_n; sel_hi = hi; out_off = off;
    @(negedge clk);
    wr_n = 1'b1; sel_lo_n = 1'b1; sel_hi = 1'b0; out_off = 1'b1;
  endtask

  task automatic get(input string req, input int a, input int exp);
    @(negedge clk);
    addr = AW'(a); wr_n = 1'b1; sel_lo_n = 1'b0; sel_hi = 1'b1; out_off = 1'b0;
    #1;
    chk({req, " doe"}, int'(doe), 1);
    chk({req, " dout"}, int'(dout), exp);
  endtask

  initial begin
    // R9: reset state, read conditions applied
    @(negedge clk);
    wr_n = 1'b1; sel_lo_n = 1'b0; sel_hi = 1'b1; out_off = 1'b0;
    #1;
    chk("R9 reset doe", int'(doe), 0);
    chk("R9 reset dout", int'(dout), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R8: exhaustive write then read sweep
    for (int a = 0; a < WORDS; a++) put(a, pat(a), 1'b0, 1'b1, 1'b0);
    for (int a = 0; a < WORDS; a++) get("R1 sweep", a, int'(pat(a)));

    // R3 R4 R2: blocked writes leave the old word; no drive
    @(negedge clk);
    addr = AW'(5); din = ~pat(5); wr_n = 1'b1; sel_lo_n = 1'b1; sel_hi = 1'b1; out_off = 1'b0;
    #1; chk("R3 lo inactive doe", int'(doe), 0); chk("R8 idle dout", int'(dout), 0);
    sel_lo_n = 1'b0; sel_hi = 1'b0;
    #1; chk("R4 hi inactive doe", int'(doe), 0);
    sel_lo_n = 1'b1; sel_hi = 1'b0;
    #1; chk("R2 both inactive doe", int'(doe), 0);
    put(5, ~pat(5), 1'b1, 1'b1, 1'b0);
    get("R3 write refused", 5, int'(pat(5)));
    put(5, ~pat(5), 1'b0, 1'b0, 1'b0);
    get("R4 write refused", 5, int'(pat(5)));
    put(5, ~pat(5), 1'b1, 1'b0, 1'b0);
    get("R2 write refused", 5, int'(pat(5)));

    // R5: output disable silences port but not writes
    @(negedge clk);
    addr = AW'(7); wr_n = 1'b1; sel_lo_n = 1'b0; sel_hi = 1'b1; out_off = 1'b1;
    #1; chk("R5 off doe", int'(doe), 0); chk("R5 off dout", int'(dout), 0);
    put(7, 4'hA, 1'b0, 1'b1, 1'b1);
    get("R5 write under off", 7, 'hA);

    // R6: strobe low, selected, output enabled -> no drive
    @(negedge clk);
    addr = AW'(8); din = 4'h3; wr_n = 1'b0; sel_lo_n = 1'b0; sel_hi = 1'b1; out_off = 1'b0;
    #1; chk("R6 strobe low doe", int'(doe), 0);
    @(negedge clk);
    wr_n = 1'b1;
    #1; chk("R6 then R8 read", int'(dout), 3);

    // R7: din changes after the edge while strobe is still low
    @(negedge clk);
    addr = AW'(9); din = 4'h6; wr_n = 1'b0; sel_lo_n = 1'b0; sel_hi = 1'b1; out_off = 1'b0;
    @(posedge clk);
    #1 din = 4'h9;
    @(negedge clk);
    wr_n = 1'b1;
    get("R7 edge sample", 9, 6);

    // R9: write blocked during reset, array kept
    @(negedge clk);
    rst_n = 1'b0;
    put(9, 4'hF, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    wr_n = 1'b1; sel_lo_n = 1'b0; sel_hi = 1'b1; out_off = 1'b0;
    #1; chk("R9 reset mid-run doe", int'(doe), 0);
    @(negedge clk);
    rst_n = 1'b1;
    get("R9 array kept", 9, 6);
    get("R9 neighbour kept", 10, int'(pat(10)));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule